// File: doc/BRIEF.md
# Exception Frame Entry/Return Sequencer

This block is the control piece of a 32-bit processor core that saves and restores machine state around an exception. On an entry request it captures the current program counter, status word, stack pointer, vector base, exception number, interrupt flag and pending interrupt level. It realigns the stack, pushes a return address and then a packed format longword, fetches the handler address from the vector table and presents the new PC, status word and stack pointer. On a return request it pops the format longword and the saved PC from the stack. It rebuilds the status word from the popped longword and puts the stack's original misalignment back into the new stack pointer.

All memory traffic goes through one 32-bit request port. That port makes one longword access at a time and holds it until the memory answers with ready. The core keeps its register file itself. It takes the three result words when the block pulses `done`, and it treats the coincident `sp_bank_swap` strobe as the moment to change the active stack bank.

Top module: `exc_frame_seq`

## Requirements
- R1: The vector offset is the exception number times 4, and the handler fetch is a read at vector base plus that offset.
- R2: The format longword holds 1 in bit 30, the pre-exception stack pointer bits 1:0 in bits 29:28, the vector offset shifted left by 16, and the old 16-bit status word in bits 15:0. All other bits are 0.
- R3: Entry performs two writes in this order: the return address to the 4-byte-aligned SP minus 4, then the format longword to aligned SP minus 8. After entry `new_sp` equals aligned SP minus 8.
- R4: When `hw_irq` is low and the exception number lies in 32..47 (software traps), the pushed return address is PC+2. In every other case it is PC.
- R5: The status word after entry has bit 13 (supervisor) set. For a hardware interrupt, bits 10:8 additionally take `irq_level` and bit 12 is cleared. Without one, all other bits keep their values.
- R6: After entry `new_pc` is the data read from the handler fetch, which is the third and last access.
- R7: Return reads the format longword at SP and then the PC at SP+4, and makes no write. `new_pc` becomes the second word and `new_sr` becomes bits 15:0 of the first.
- R8: After return `new_sp` is SP+8 with format bits 29:28 ORed into its bits 1:0.
- R9: Only one access is outstanding at any time. While `mem_ready` is low, `mem_req`, `mem_we`, `mem_addr` and `mem_wdata` hold steady.
- R10: `done` and `sp_bank_swap` pulse together for exactly one cycle, in the first cycle in which the outputs carry their new values. `busy` is high from the cycle after acceptance until that cycle.
- R11: Requests that arrive while `busy` is high are ignored, and so are input changes during a sequence. If both requests arrive together while idle, the entry request wins.
- R12: After reset `new_pc`, `new_sr` and `new_sp` are 0, and `mem_req`, `busy`, `done` and `sp_bank_swap` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| entry_req | input | 1 | Start an exception entry (taken when idle) |
| return_req | input | 1 | Start a return from exception (taken when idle) |
| hw_irq | input | 1 | Entry is caused by a hardware interrupt |
| exc_num | input | EXC_W | Exception number |
| irq_level | input | IPL_W | Pending interrupt level |
| cur_pc | input | 32 | Current program counter |
| cur_sr | input | 16 | Current status word |
| cur_sp | input | 32 | Current stack pointer |
| vbr | input | 32 | Vector table base address |
| mem_req | output | 1 | Memory access request |
| mem_we | output | 1 | Access is a write |
| mem_addr | output | 32 | Access address |
| mem_wdata | output | 32 | Write data |
| mem_rdata | input | 32 | Read data, valid with mem_ready |
| mem_ready | input | 1 | Memory completes the access this cycle |
| new_pc | output | 32 | Resulting program counter |
| new_sr | output | 16 | Resulting status word |
| new_sp | output | 32 | Resulting stack pointer |
| sp_bank_swap | output | 1 | One-cycle strobe to switch the active stack bank |
| done | output | 1 | One-cycle pulse: results valid |
| busy | output | 1 | A sequence is in progress |

## Verification
The bench drives stack pointers with every value of bits 1:0. A design that forgot to realign would write to odd addresses, and one that dropped the misalignment would produce a wrong format word and a wrong restored SP. Exception numbers 31, 32, 47 and 48 sit on both edges of the trap range, and a hardware interrupt inside that range shows whether the +2 return-address adjustment leaks into the interrupt path. Random stalls on `mem_ready`, together with changed inputs and new requests in the middle of a sequence, expose a design that skips a handshake, reorders accesses or re-samples its inputs. A simultaneous entry and return request shows which one wins.

// File: rtl/exc_frame_pkg.sv
// Package: shared state encoding and status-word / frame field positions
// for the exception frame sequencer. Assumes a 16-bit status word and a
// 32-bit address and data path.
package exc_frame_pkg;

    localparam int XLEN       = 32;
    localparam int SR_W       = 16;
    localparam int SR_S_BIT   = 13;   // supervisor
    localparam int SR_M_BIT   = 12;   // master / interrupt-state
    localparam int SR_IPL_LO  = 8;    // interrupt mask, low bit
    localparam int FMT_MARK   = 30;   // always-one marker in frame word
    localparam int FMT_MIS_LO = 28;   // saved SP misalignment
    localparam int FMT_VEC_LO = 16;   // vector offset position

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_PUSH_RA,
        ST_PUSH_FMT,
        ST_FETCH_VEC,
        ST_POP_FMT,
        ST_POP_PC
    } seq_state_t;

endpackage

// File: rtl/exc_entry_calc.sv
// Entry arithmetic: from a captured snapshot, computes the aligned push
// addresses, the packed format longword, the return address, the status
// word after entry and the handler fetch address. Purely combinational.
// Assumes EXC_W + 2 <= 12 so the vector offset stays below bit 28.
module exc_entry_calc
    import exc_frame_pkg::*;
#(
    parameter int EXC_W     = 8,
    parameter int IPL_W     = 3,
    parameter int TRAP_BASE = 32
) (
    input  logic [XLEN-1:0]  pc,
    input  logic [SR_W-1:0]  sr,
    input  logic [XLEN-1:0]  sp,
    input  logic [XLEN-1:0]  vbr,
    input  logic [EXC_W-1:0] num,
    input  logic             hw,
    input  logic [IPL_W-1:0] lvl,
    output logic [XLEN-1:0]  ra_addr,
    output logic [XLEN-1:0]  fw_addr,
    output logic [XLEN-1:0]  fmt_word,
    output logic [XLEN-1:0]  ret_addr,
    output logic [SR_W-1:0]  entry_sr,
    output logic [XLEN-1:0]  vec_addr
);

    localparam logic [EXC_W:0] TRAP_LO = (EXC_W+1)'(TRAP_BASE);
    localparam logic [EXC_W:0] TRAP_HI = (EXC_W+1)'(TRAP_BASE + 15);

    logic [XLEN-1:0] vec_off;
    logic [XLEN-1:0] sp_al;
    logic            is_trap;

    // Vector offset, stack realignment and trap-range decode.
    always_comb begin
        vec_off = XLEN'({num, 2'b00});
        sp_al   = {sp[XLEN-1:2], 2'b00};
        is_trap = !hw && ({1'b0, num} >= TRAP_LO) && ({1'b0, num} <= TRAP_HI);
    end

    // Frame contents and addresses.
    always_comb begin
        ra_addr  = sp_al - XLEN'(4);
        fw_addr  = sp_al - XLEN'(8);
        ret_addr = is_trap ? pc + XLEN'(2) : pc;
        vec_addr = vbr + vec_off;
        fmt_word = (XLEN'(1) << FMT_MARK)
                 | (XLEN'(sp[1:0]) << FMT_MIS_LO)
                 | (vec_off << FMT_VEC_LO)
                 | XLEN'(sr);
    end

    // Status word after entry: supervisor always, mask and M for interrupts.
    always_comb begin
        entry_sr = sr;
        entry_sr[SR_S_BIT] = 1'b1;
        if (hw) begin
            entry_sr[SR_IPL_LO +: IPL_W] = lvl;
            entry_sr[SR_M_BIT]           = 1'b0;
        end
    end

endmodule

// File: rtl/exc_unwind_calc.sv
// Return arithmetic: from the stack pointer and the fields kept from the
// popped format longword, computes the PC pop address, restored status word
// and restored stack pointer. Purely combinational.
module exc_unwind_calc
    import exc_frame_pkg::*;
(
    input  logic [XLEN-1:0] sp,
    input  logic [SR_W-1:0] fmt_sr,
    input  logic [1:0]      fmt_mis,
    output logic [XLEN-1:0] pc_addr,
    output logic [SR_W-1:0] unwind_sr,
    output logic [XLEN-1:0] unwind_sp
);

    logic [XLEN-1:0] sum8;

    // Pop address for the PC and the restored SP with misalignment ORed back.
    always_comb begin
        pc_addr   = sp + XLEN'(4);
        sum8      = sp + XLEN'(8);
        unwind_sp = {sum8[XLEN-1:2], sum8[1:0] | fmt_mis};
        unwind_sr = fmt_sr;
    end

endmodule

// File: rtl/exc_seq_fsm.sv
// Sequence controller: walks entry (push RA, push format, fetch vector) or
// return (pop format, pop PC), one memory access per state, advancing only
// on mem_ready. Entry wins when both requests arrive together. Requests are
// looked at only in the idle state.
module exc_seq_fsm
    import exc_frame_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       entry_req,
    input  logic       return_req,
    input  logic       mem_ready,
    output seq_state_t state,
    output logic       accept,
    output logic       ack,
    output logic       last_ack
);

    seq_state_t nxt;

    // Request acceptance and handshake decode.
    always_comb begin
        accept   = (state == ST_IDLE) && (entry_req || return_req);
        ack      = (state != ST_IDLE) && mem_ready;
        last_ack = ack && (state == ST_FETCH_VEC || state == ST_POP_PC);
    end

    // Next-state selection.
    always_comb begin
        nxt = state;
        unique case (state)
            ST_IDLE:      if (entry_req) nxt = ST_PUSH_RA;
                          else if (return_req) nxt = ST_POP_FMT;
            ST_PUSH_RA:   if (ack) nxt = ST_PUSH_FMT;
            ST_PUSH_FMT:  if (ack) nxt = ST_FETCH_VEC;
            ST_FETCH_VEC: if (ack) nxt = ST_IDLE;
            ST_POP_FMT:   if (ack) nxt = ST_POP_PC;
            ST_POP_PC:    if (ack) nxt = ST_IDLE;
            default:      nxt = ST_IDLE;
        endcase
    end

    // State register.
    always_ff @(posedge clk) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= nxt;
    end

    // R11
    busy_ignores_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state != ST_IDLE && !ack) |=> $stable(state));

endmodule

// File: rtl/exc_frame_seq.sv
// Top: exception frame entry/return sequencer. Captures the core's state on
// an accepted request, drives one longword access at a time on the memory
// port and presents new PC/SR/SP with a one-cycle done pulse and stack-bank
// strobe. Assumes the memory holds mem_rdata valid in the mem_ready cycle.
module exc_frame_seq
    import exc_frame_pkg::*;
#(
    parameter int EXC_W     = 8,
    parameter int IPL_W     = 3,
    parameter int TRAP_BASE = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             entry_req,
    input  logic             return_req,
    input  logic             hw_irq,
    input  logic [EXC_W-1:0] exc_num,
    input  logic [IPL_W-1:0] irq_level,
    input  logic [31:0]      cur_pc,
    input  logic [15:0]      cur_sr,
    input  logic [31:0]      cur_sp,
    input  logic [31:0]      vbr,
    output logic             mem_req,
    output logic             mem_we,
    output logic [31:0]      mem_addr,
    output logic [31:0]      mem_wdata,
    input  logic [31:0]      mem_rdata,
    input  logic             mem_ready,
    output logic [31:0]      new_pc,
    output logic [15:0]      new_sr,
    output logic [31:0]      new_sp,
    output logic             sp_bank_swap,
    output logic             done,
    output logic             busy
);

    seq_state_t       state;
    logic             accept, ack, last_ack;
    logic [XLEN-1:0]  snap_pc, snap_sp, snap_vbr;
    logic [SR_W-1:0]  snap_sr;
    logic [EXC_W-1:0] snap_num;
    logic             snap_hw;
    logic [IPL_W-1:0] snap_lvl;
    logic             seq_is_entry;
    logic [SR_W-1:0]  pop_sr;
    logic [1:0]       pop_mis;
    logic [XLEN-1:0]  ra_addr, fw_addr, fmt_word, ret_addr, vec_addr;
    logic [SR_W-1:0]  entry_sr;
    logic [XLEN-1:0]  pc_addr, unwind_sp;
    logic [SR_W-1:0]  unwind_sr;

    exc_seq_fsm u_fsm (
        .clk        (clk),
        .rst_n      (rst_n),
        .entry_req  (entry_req),
        .return_req (return_req),
        .mem_ready  (mem_ready),
        .state      (state),
        .accept     (accept),
        .ack        (ack),
        .last_ack   (last_ack)
    );

    exc_entry_calc #(
        .EXC_W     (EXC_W),
        .IPL_W     (IPL_W),
        .TRAP_BASE (TRAP_BASE)
    ) u_entry (
        .pc       (snap_pc),
        .sr       (snap_sr),
        .sp       (snap_sp),
        .vbr      (snap_vbr),
        .num      (snap_num),
        .hw       (snap_hw),
        .lvl      (snap_lvl),
        .ra_addr  (ra_addr),
        .fw_addr  (fw_addr),
        .fmt_word (fmt_word),
        .ret_addr (ret_addr),
        .entry_sr (entry_sr),
        .vec_addr (vec_addr)
    );

    exc_unwind_calc u_unwind (
        .sp        (snap_sp),
        .fmt_sr    (pop_sr),
        .fmt_mis   (pop_mis),
        .pc_addr   (pc_addr),
        .unwind_sr (unwind_sr),
        .unwind_sp (unwind_sp)
    );

    // Snapshot of the core's state at acceptance; frozen for the sequence.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            snap_pc      <= '0;
            snap_sr      <= '0;
            snap_sp      <= '0;
            snap_vbr     <= '0;
            snap_num     <= '0;
            snap_hw      <= 1'b0;
            snap_lvl     <= '0;
            seq_is_entry <= 1'b0;
        end else if (accept) begin
            snap_pc      <= cur_pc;
            snap_sr      <= cur_sr;
            snap_sp      <= cur_sp;
            snap_vbr     <= vbr;
            snap_num     <= exc_num;
            snap_hw      <= hw_irq;
            snap_lvl     <= irq_level;
            seq_is_entry <= entry_req;
        end
    end

    // Keep the fields of the popped format longword that the return needs.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pop_sr  <= '0;
            pop_mis <= '0;
        end else if (ack && state == ST_POP_FMT) begin
            pop_sr  <= mem_rdata[SR_W-1:0];
            pop_mis <= mem_rdata[FMT_MIS_LO +: 2];
        end
    end

    // Memory port: address, direction and data for the current state.
    always_comb begin
        mem_req   = (state != ST_IDLE);
        mem_we    = 1'b0;
        mem_addr  = '0;
        mem_wdata = '0;
        unique case (state)
            ST_PUSH_RA:   begin mem_we = 1'b1; mem_addr = ra_addr; mem_wdata = ret_addr; end
            ST_PUSH_FMT:  begin mem_we = 1'b1; mem_addr = fw_addr; mem_wdata = fmt_word; end
            ST_FETCH_VEC: mem_addr = vec_addr;
            ST_POP_FMT:   mem_addr = snap_sp;
            ST_POP_PC:    mem_addr = pc_addr;
            default:      mem_addr = '0;
        endcase
        busy = mem_req;
    end

    // Result registers and the done / bank-swap pulses.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            new_pc       <= '0;
            new_sr       <= '0;
            new_sp       <= '0;
            done         <= 1'b0;
            sp_bank_swap <= 1'b0;
        end else begin
            done         <= last_ack;
            sp_bank_swap <= last_ack;
            if (last_ack) begin
                new_pc <= mem_rdata;
                new_sr <= seq_is_entry ? entry_sr : unwind_sr;
                new_sp <= seq_is_entry ? fw_addr  : unwind_sp;
            end
        end
    end

    // R9
    mem_req_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && !mem_ready) |=> (mem_req && $stable(mem_addr)
                                     && $stable(mem_we) && $stable(mem_wdata)));

    // R10
    done_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    // R3
    entry_write_align_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && mem_we) |-> (mem_addr[1:0] == 2'b00));

    // R5
    entry_super_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (done && seq_is_entry) |-> new_sr[SR_S_BIT]);

    // R7
    return_no_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && !seq_is_entry) |-> !mem_we);

endmodule

// File: tb/exc_frame_seq_test.sv
// Bench: behavioural reference model (expected access queue plus expected
// results) compared against the design on every falling clock edge.
module exc_frame_seq_test;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        entry_req = 1'b0, return_req = 1'b0, hw_irq = 1'b0;
    logic [7:0]  exc_num = '0;
    logic [2:0]  irq_level = '0;
    logic [31:0] cur_pc = '0, cur_sp = '0, vbr = '0;
    logic [15:0] cur_sr = '0;
    logic        mem_req, mem_we, mem_ready = 1'b1;
    logic [31:0] mem_addr, mem_wdata, mem_rdata;
    logic [31:0] new_pc, new_sp;
    logic [15:0] new_sr;
    logic        sp_bank_swap, done, busy;

    exc_frame_seq uut (
        .clk(clk), .rst_n(rst_n), .entry_req(entry_req), .return_req(return_req),
        .hw_irq(hw_irq), .exc_num(exc_num), .irq_level(irq_level),
        .cur_pc(cur_pc), .cur_sr(cur_sr), .cur_sp(cur_sp), .vbr(vbr),
        .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr),
        .mem_wdata(mem_wdata), .mem_rdata(mem_rdata), .mem_ready(mem_ready),
        .new_pc(new_pc), .new_sr(new_sr), .new_sp(new_sp),
        .sp_bank_swap(sp_bank_swap), .done(done), .busy(busy)
    );

    always #10 clk = ~clk;   // 50 MHz

    typedef struct {
        logic        we;
        logic [31:0] addr;
        logic [31:0] data;
        string       tag;
    } acc_t;

    acc_t        exp_q[$];
    logic [31:0] exp_pc, exp_sp;
    logic [15:0] exp_sr;
    string       exp_tag;
    bit          pending = 1'b0;
    bit          stall = 1'b0;
    logic [15:0] lfsr = 16'hACE1;
    int          n_cmp = 0, n_bad = 0, cycles = 0;

    logic [31:0] rd_fmt_addr = 32'hFFFF_FFF0, rd_fmt = '0;
    logic [31:0] rd_pc_addr  = 32'hFFFF_FFF4, rd_pc  = '0;

    function automatic logic [31:0] vec_data(input logic [31:0] a);
        return a ^ 32'hC3A5_0F69;
    endfunction

    // Memory model: return-frame words at chosen addresses, else a hash.
    always_comb begin
        if (mem_addr == rd_fmt_addr)     mem_rdata = rd_fmt;
        else if (mem_addr == rd_pc_addr) mem_rdata = rd_pc;
        else                             mem_rdata = vec_data(mem_addr);
    end

    task automatic chk(input bit ok, input string tag,
                       input logic [31:0] act, input logic [31:0] exp);
        n_cmp++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // Per-cycle comparison against the model; also drives mem_ready.
    always @(negedge clk) begin
        if (rst_n) begin
            lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
            mem_ready = !stall || lfsr[1] || lfsr[4];
            chk(busy == (pending && !done), "R10 busy", 32'(busy), 32'(pending && !done));
            chk(sp_bank_swap == done, "R10 strobe", 32'(sp_bank_swap), 32'(done));
            if (done) begin
                if (!pending) chk(1'b0, "R11 unexpected done", 1, 0);
                else begin
                    chk(new_pc == exp_pc, {exp_tag, " pc"}, new_pc, exp_pc);
                    chk(new_sr == exp_sr, {exp_tag, " sr"}, 32'(new_sr), 32'(exp_sr));
                    chk(new_sp == exp_sp, {exp_tag, " sp"}, new_sp, exp_sp);
                end
                pending = 1'b0;
            end
            if (mem_req && mem_ready) begin
                if (exp_q.size() == 0) chk(1'b0, "R11 extra access", mem_addr, 0);
                else begin
                    acc_t e;
                    e = exp_q.pop_front();
                    chk(mem_we == e.we, {e.tag, " dir"}, 32'(mem_we), 32'(e.we));
                    chk(mem_addr == e.addr, {e.tag, " addr"}, mem_addr, e.addr);
                    if (e.we) chk(mem_wdata == e.data, {e.tag, " data"}, mem_wdata, e.data);
                end
            end
        end
    end

    // Watchdog.
    always @(posedge clk) begin
        cycles++;
        if (cycles > 60000) begin
            n_bad++;
            $display("FAIL watchdog expired");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    task automatic do_entry(input logic [31:0] pc, input logic [15:0] sr,
                            input logic [31:0] sp, input logic [31:0] vb,
                            input logic [7:0] num, input bit hw,
                            input logic [2:0] lvl, input bit poke, input bit both);
        logic [31:0] spa, ra, vec, fmt;
        logic [15:0] s;
        wait (!pending && !busy);
        @(posedge clk); #2;
        cur_pc = pc; cur_sr = sr; cur_sp = sp; vbr = vb;
        exc_num = num; hw_irq = hw; irq_level = lvl;
        entry_req = 1'b1; return_req = both;
        spa = sp & ~32'd3;
        ra  = (!hw && num >= 32 && num <= 47) ? pc + 2 : pc;
        vec = 32'(num) * 4;
        fmt = 32'h4000_0000 | ((sp & 32'd3) << 28) | (vec << 16) | 32'(sr);
        exp_q.push_back('{1'b1, spa - 4, ra,  "R3 R4 R9"});
        exp_q.push_back('{1'b1, spa - 8, fmt, "R2 R3 R9"});
        exp_q.push_back('{1'b0, vb + vec, 32'd0, "R1 R9"});
        s = sr | 16'h2000;
        if (hw) s = (s & ~16'h1700) | (16'(lvl) << 8);
        exp_pc = vec_data(vb + vec); exp_sr = s; exp_sp = spa - 8;
        exp_tag = both ? "R11 R3 R5 R6" : "R3 R5 R6";
        @(posedge clk); #2;
        entry_req = 1'b0; return_req = 1'b0; pending = 1'b1;
        cur_pc = ~pc; cur_sr = ~sr; cur_sp = ~sp; vbr = ~vb;
        exc_num = ~num; hw_irq = ~hw; irq_level = ~lvl;
        if (poke) begin
            @(posedge clk); #2; entry_req = 1'b1; return_req = 1'b1;
            @(posedge clk); #2; entry_req = 1'b0; return_req = 1'b0;
        end
        wait (!pending);
    endtask

    task automatic do_return(input logic [31:0] sp, input logic [31:0] fmt,
                             input logic [31:0] pc, input bit poke);
        wait (!pending && !busy);
        @(posedge clk); #2;
        rd_fmt_addr = sp; rd_fmt = fmt; rd_pc_addr = sp + 4; rd_pc = pc;
        cur_sp = sp; return_req = 1'b1;
        exp_q.push_back('{1'b0, sp,     32'd0, "R7 R9"});
        exp_q.push_back('{1'b0, sp + 4, 32'd0, "R7 R9"});
        exp_pc = pc; exp_sr = fmt[15:0];
        exp_sp = (sp + 8) | ((fmt >> 28) & 32'd3);
        exp_tag = "R7 R8";
        @(posedge clk); #2;
        return_req = 1'b0; pending = 1'b1; cur_sp = ~sp;
        if (poke) begin
            @(posedge clk); #2; entry_req = 1'b1; return_req = 1'b1;
            @(posedge clk); #2; entry_req = 1'b0; return_req = 1'b0;
        end
        wait (!pending);
        rd_fmt_addr = 32'hFFFF_FFF0; rd_pc_addr = 32'hFFFF_FFF4;
    endtask

    initial begin
        repeat (3) @(posedge clk);
        #2 rst_n = 1'b1;
        @(negedge clk); #1;
        // R12 reset state
        chk(new_pc == 0 && new_sp == 0 && new_sr == 0, "R12 results", new_pc, 0);
        chk(!mem_req && !busy && !done && !sp_bank_swap, "R12 controls",
            32'({mem_req, busy, done, sp_bank_swap}), 0);

        do_entry(32'h0000_4000, 16'h0004, 32'h0007_0F00, 32'h0000_1000, 8'd2,  1'b0, 3'd0, 1'b0, 1'b0);
        do_entry(32'h0000_4100, 16'h0711, 32'h0007_0E03, 32'h0000_1000, 8'd32, 1'b0, 3'd0, 1'b0, 1'b0); // R4 low edge
        do_entry(32'h0000_4200, 16'h1010, 32'h0007_0D01, 32'h0000_2000, 8'd31, 1'b0, 3'd0, 1'b0, 1'b0); // R4 below
        do_entry(32'h0000_4300, 16'h0000, 32'h0007_0C02, 32'h0000_2000, 8'd48, 1'b0, 3'd0, 1'b0, 1'b0); // R4 above
        do_entry(32'h0000_4400, 16'h1715, 32'h0007_0B00, 32'h0000_3000, 8'd25, 1'b1, 3'd5, 1'b0, 1'b0); // R5 hw
        do_entry(32'h0000_4500, 16'h0300, 32'h0007_0A01, 32'h0000_3000, 8'd40, 1'b1, 3'd2, 1'b0, 1'b0); // R4 hw in trap range
        do_entry(32'h0000_4600, 16'hFFFF, 32'h0007_0903, 32'h0000_0000, 8'd255, 1'b0, 3'd0, 1'b0, 1'b0); // R1 max vector
        do_return(32'h0008_0000, 32'h4378_2704, 32'h0000_5000, 1'b0);
        do_return(32'h0008_0100, 32'h5078_0015, 32'h0000_5100, 1'b0);   // R8 mis=01
        stall = 1'b1;
        do_entry(32'h0000_4700, 16'h0123, 32'h0007_0801, 32'h0000_1000, 8'd47, 1'b0, 3'd0, 1'b0, 1'b0); // R4 high edge, R9
        do_return(32'h0008_0200, 32'h7088_2000, 32'h0000_5200, 1'b0);   // R8 mis=11, R9
        do_entry(32'h0000_4800, 16'h2000, 32'h0007_0702, 32'h0000_1000, 8'd3, 1'b1, 3'd7, 1'b1, 1'b0);  // R11 poke
        do_return(32'h0008_0300, 32'h6000_0700, 32'h0000_5300, 1'b1);   // R11 poke
        stall = 1'b0;
        do_entry(32'h0000_4900, 16'h0001, 32'h0007_0600, 32'h0000_1000, 8'd9, 1'b0, 3'd0, 1'b1, 1'b1);  // R11 priority
        repeat (4) @(posedge clk);
        chk(exp_q.size() == 0, "R11 leftover accesses", exp_q.size(), 0);
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

endmodule